// File: doc/BRIEF.md
# Serial NOR Flash Command Controller

This block lets software issue single commands to as many as four serial NOR flash devices that share one SPI-style bus. Each device has its own active-low chip select. Software sets up the timing in one configuration register: the serial clock divider, the chip-select hold time and the deselect gap. It then writes a command register that names a bank and one of two commands. The controller selects that bank and drives the opcode in SPI mode 0, most significant bit first. The two commands are: read the device status byte (opcode 0x05), or set the device's write-enable latch (opcode 0x06).

When a command ends, the controller sets a sticky finished flag in its status register. If the command was a status read, the status register also holds the returned byte. If it was a write enable, a per-bank write-mode bit is set. An interrupt line follows the finished flag when the command register's interrupt enable bit is set. A write of zero to the status register clears every pending condition. Software typically polls the status byte until the device's busy bit drops, then issues a write enable before any program or erase.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset, the status word reads 0, all chip selects are high, the serial clock is low and the interrupt is low.
- R2: A write at address 0x4 starts a command when all of the following hold: exactly one of bit 0 (status read) and bit 1 (write enable) is set, the controller is idle, configuration bit 0 (software mode) is 0, and configuration bit 2 (bank enable) is 1. Only the chip select of the bank in bits 13:12 goes low, and it stays low for the whole command.
- R3: A status read shifts out 0x05 followed by 8 further clocks. The byte captured on those 8 rising edges appears in status bits 7:0, and status bits 15:8 read zero.
- R4: A write enable shifts out 0x06 in 8 clocks. On completion it sets status bit 20+bank (write-mode bit) and leaves bits 7:0 unchanged.
- R5: Completion sets status bit 16 (finished). Starting a new command clears that bit.
- R6: The interrupt output is high exactly while the finished bit and command-register bit 3 (interrupt enable) are both set. Rewriting the command register with bit 3 clear lowers the interrupt and keeps the finished bit.
- R7: Writing 0 to address 0x8 clears the finished bit, all write-mode bits and the status byte. A nonzero write to 0x8 changes nothing.
- R8: Status bit 17 (busy) reads 1 while a command runs. Any write to address 0x4 during that time is ignored and selects no other bank.
- R9: While software mode is set or bank enable is clear, a command write starts nothing: no chip select falls and the status word stays unchanged.
- R10: Each serial clock phase lasts max(floor(P/2),1) functional clocks, where P is configuration bits 15:8.
- R11: With hold count H in configuration bits 19:16 and deselect count D in bits 23:20, the finished bit is set 2H+D+3+2·N·max(floor(P/2),1) clocks after the edge that accepts the command. N is 16 for a status read and 8 for a write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address (0x0 config, 0x4 command, 0x8 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | NBANK | Active-low chip select per bank |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| irq | output | 1 | Command-finished interrupt |

## Verification
The finished flag and interrupt are due a fixed number of clocks after the accepting edge, given by the R11 formula. That formula covers the hold count, the serial clock phase length, the bit count and the deselect gap. The scoreboard stores this latency with each expected status word and counts clock edges from the write until the interrupt is first seen at a falling edge. It then reads the status word in that same cycle and compares both values. The busy and ignored-write checks read the status word partway through a command. The disabled-mode checks wait well past the longest possible command and then confirm that no chip select ever fell.

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int NBANK    = 4,
  parameter int WM_SHIFT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             sck,
  output logic [NBANK-1:0] cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             irq
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [31:0] CFG_MASK = 32'h00FF_FF07;
  localparam logic [31:0] CMD_MASK = 32'h0000_300B;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_DESEL} st_t;
  st_t st;

  logic [31:0] cfg, cmd;
  logic [7:0]  stat_byte, rx, cnt, hcnt;
  logic [15:0] tx;
  logic [4:0]  bitcnt;
  logic [NBANK-1:0] wm;
  logic [BW-1:0] bank;
  logic tff, is_rd, sck_r;

  wire busy    = (st != S_IDLE);
  wire wr_cfg  = reg_we && reg_addr == 4'h0;
  wire wr_cmd  = reg_we && reg_addr == 4'h4 && !busy;
  wire wr_stat = reg_we && reg_addr == 4'h8 && reg_wdata == 32'd0;
  wire start   = wr_cmd && !cfg[0] && cfg[2] && (reg_wdata[0] ^ reg_wdata[1]);

  wire [7:0] half    = (cfg[15:9] == 7'd0) ? 8'd1 : {1'b0, cfg[15:9]};
  wire [7:0] hold_n  = {4'd0, cfg[19:16]};
  wire [7:0] desel_n = {4'd0, cfg[23:20]};
  wire [4:0] last    = is_rd ? 5'd15 : 5'd7;

  wire [31:0] stat_word = (32'(wm) << WM_SHIFT) | (32'(busy) << 17) |
                          (32'(tff) << 16) | {24'd0, stat_byte};

  always_comb begin
    case (reg_addr)
      4'h0:    reg_rdata = cfg;
      4'h4:    reg_rdata = cmd;
      4'h8:    reg_rdata = stat_word;
      default: reg_rdata = 32'd0;
    endcase
  end

  wire cs_act = (st == S_SETUP) || (st == S_SHIFT) || (st == S_HOLD);
  assign cs_n = cs_act ? ~(NBANK'(1) << bank) : '1;
  assign sck  = sck_r;
  assign mosi = (st == S_SHIFT) ? tx[15] : 1'b0;
  assign irq  = tff && cmd[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      cmd <= '0;
    end else begin
      if (wr_cfg) cfg <= reg_wdata & CFG_MASK;
      if (wr_cmd) cmd <= reg_wdata & CMD_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      stat_byte <= '0;
      rx <= '0;
      tx <= '0;
      cnt <= '0;
      hcnt <= '0;
      bitcnt <= '0;
      wm <= '0;
      bank <= '0;
      tff <= 1'b0;
      is_rd <= 1'b0;
      sck_r <= 1'b0;
    end else begin
      if (wr_stat) begin
        tff <= 1'b0;
        wm <= '0;
        stat_byte <= '0;
      end
      case (st)
        S_IDLE: if (start) begin
          st <= S_SETUP;
          cnt <= '0;
          bank <= reg_wdata[12 +: BW];
          is_rd <= reg_wdata[0];
          tx <= {(reg_wdata[0] ? 8'h05 : 8'h06), 8'h00};
          tff <= 1'b0;
        end
        S_SETUP: begin
          if (cnt >= hold_n) begin
            st <= S_SHIFT;
            hcnt <= '0;
            bitcnt <= '0;
            sck_r <= 1'b0;
          end else cnt <= cnt + 8'd1;
        end
        S_SHIFT: begin
          if (hcnt >= half - 8'd1) begin
            hcnt <= '0;
            sck_r <= ~sck_r;
            if (!sck_r) rx <= {rx[6:0], miso};
            else begin
              tx <= {tx[14:0], 1'b0};
              if (bitcnt == last) begin
                st <= S_HOLD;
                cnt <= '0;
              end else bitcnt <= bitcnt + 5'd1;
            end
          end else hcnt <= hcnt + 8'd1;
        end
        S_HOLD: begin
          if (cnt >= hold_n) begin
            st <= S_DESEL;
            cnt <= '0;
          end else cnt <= cnt + 8'd1;
        end
        S_DESEL: begin
          if (cnt >= desel_n) begin
            st <= S_IDLE;
            tff <= 1'b1;
            if (is_rd) stat_byte <= rx;
            else wm[bank] <= 1'b1;
          end else cnt <= cnt + 8'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck,
  input logic [NBANK-1:0] cs_n,
  input logic             mosi,
  input logic             busy,
  input logic             tff
);
  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sck);

  // R3
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R5
  tff_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tff) |-> $past(busy));

  // R8
  busy_no_tff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tff);
endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
  .mosi(mosi), .busy(busy), .tff(tff)
);

// File: tb/test_nor_cmd_ctrl.sv
module test_nor_cmd_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic sck, mosi, irq;
  logic miso = 1'b0;
  logic [3:0] cs_n;

  nor_cmd_ctrl i_nor_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .irq(irq)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // flash responder
  logic [7:0] fop = 8'd0;
  int fcnt = 0;
  int fbank = 0;
  logic [3:0] wel = 4'd0;
  logic was_act = 1'b0;
  logic psck = 1'b0;
  logic any_cs = 1'b0;
  logic cs_bad = 1'b0;
  int exp_bank = 0;

  function automatic logic [7:0] fstat(input int b);
    return 8'h40 | 8'(b << 3) | {6'd0, wel[b], 1'b0};
  endfunction

  always @(negedge clk) begin
    if (&cs_n) begin
      if (was_act && fcnt >= 8 && fop == 8'h06) wel[fbank] = 1'b1;
      was_act = 1'b0;
      fcnt = 0;
      miso = 1'b0;
    end else begin
      logic [7:0] s;
      any_cs = 1'b1;
      was_act = 1'b1;
      if (cs_n != ~(4'b1 << exp_bank)) cs_bad = 1'b1;
      for (int b = 0; b < 4; b++) if (!cs_n[b]) fbank = b;
      if (sck && !psck) begin
        if (fcnt < 8) fop = {fop[6:0], mosi};
        fcnt++;
      end
      if (!sck && psck && fcnt >= 8 && fcnt < 16 && fop == 8'h05) begin
        s = fstat(fbank);
        miso = s[15 - fcnt];
      end
    end
    psck = sck;
  end

  // scoreboard
  typedef struct {
    logic [31:0] sr;
    int lat;
    string tag;
  } item_t;
  item_t q[$];
  int start_cyc = 0;
  int pend = 0;
  int done = 0;

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_wdata = d;
    reg_we = 1'b1;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] cmdw(input bit is_rd, input int b);
    return (is_rd ? 32'h1 : 32'h2) | 32'h8 | (32'(b) << 12);
  endfunction

  task automatic start_cmd(input bit is_rd, input int b, input logic [31:0] sr,
                           input int lat, input string tag);
    item_t it;
    exp_bank = b;
    cs_bad = 1'b0;
    wr(4'h4, cmdw(is_rd, b));
    start_cyc = cyc;
    it.sr = sr;
    it.lat = lat;
    it.tag = tag;
    q.push_back(it);
    pend++;
  endtask

  task automatic wait_done();
    wait (done == pend);
  endtask

  initial begin
    forever begin
      wait (q.size() > 0);
      @(negedge clk);
      if (irq) begin
        item_t it;
        int lat;
        it = q.pop_front();
        lat = cyc - start_cyc;
        reg_addr = 4'h8;
        #1;
        check({it.tag, " status"}, reg_rdata, it.sr);
        check({it.tag, " R11 latency"}, 32'(lat), 32'(it.lat));
        check({it.tag, " R2 chip select"}, {31'd0, cs_bad}, 32'd0);
        done++;
      end
    end
  end

  function automatic logic [31:0] cfgw(input int p, input int h, input int d);
    return 32'h4 | (32'(p) << 8) | (32'(h) << 16) | (32'(d) << 20);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1
    rd(4'h8, v);
    check("R1 status", v, 32'd0);
    check("R1 cs_n", {28'd0, cs_n}, 32'hF);
    check("R1 sck irq", {30'd0, sck, irq}, 32'd0);

    wr(4'h0, cfgw(4, 1, 2));
    // R4 R5 R6: write enable bank 2
    start_cmd(1'b0, 2, 32'h0041_0000, 39, "R4 R5 R6");
    wait_done();
    // R7
    wr(4'h8, 32'h1);
    rd(4'h8, v);
    check("R7 nonzero write ignored", v, 32'h0041_0000);
    wr(4'h8, 32'h0);
    rd(4'h8, v);
    check("R7 clear", v, 32'd0);
    check("R7 irq low", {31'd0, irq}, 32'd0);

    // R3: status read bank 2 sees write-enable latch
    start_cmd(1'b1, 2, 32'h0001_0052, 71, "R3 R5");
    wait_done();
    // R6: drop interrupt enable
    wr(4'h4, 32'h0);
    rd(4'h8, v);
    check("R6 irq off", {31'd0, irq}, 32'd0);
    check("R6 flag kept", v, 32'h0001_0052);
    wr(4'h8, 32'h0);

    // R8: busy and ignored command
    start_cmd(1'b1, 0, 32'h0001_0040, 71, "R8 R3");
    repeat (10) @(posedge clk);
    wr(4'h4, cmdw(1'b0, 3));
    rd(4'h8, v);
    check("R8 busy", {31'd0, v[17]}, 32'd1);
    wait_done();
    check("R8 no bank 3", {31'd0, wel[3]}, 32'd0);
    wr(4'h8, 32'h0);

    // R9: software mode, then bank disabled
    any_cs = 1'b0;
    wr(4'h0, cfgw(4, 1, 2) | 32'h1);
    wr(4'h4, cmdw(1'b1, 1));
    repeat (200) @(posedge clk);
    rd(4'h8, v);
    check("R9 software mode status", v, 32'd0);
    check("R9 software mode cs", {31'd0, any_cs}, 32'd0);
    wr(4'h0, cfgw(4, 1, 2) & ~32'h4);
    wr(4'h4, cmdw(1'b0, 1));
    repeat (200) @(posedge clk);
    rd(4'h8, v);
    check("R9 bank disabled status", v, 32'd0);
    check("R9 bank disabled cs", {31'd0, any_cs}, 32'd0);

    // R10: prescaler 6 -> phase 3, no hold or gap
    wr(4'h0, cfgw(6, 0, 0));
    start_cmd(1'b1, 1, 32'h0001_0048, 99, "R10 R3");
    wait_done();
    // R10: prescaler 0 -> phase 1, hold 3, gap 5
    wr(4'h0, cfgw(0, 3, 5));
    start_cmd(1'b0, 1, 32'h0021_0048, 30, "R10 R4");
    wait_done();
    start_cmd(1'b1, 1, 32'h0021_004A, 46, "R10 R3 R5");
    wait_done();

    repeat (5) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule